// File: doc/BRIEF.md
# Diagnostic Data Buffer FIFO

This block is a 16-bit data buffer register that sits on a first-in first-out store so that software can exercise the buffer and its two status flags. A bus write to the data register pushes one word. A bus read pops one word. The store holds 66 words, and the depth is a parameter. The block does not move disk or tape data. It exists only so that the buffer behaviour can be tested.

The block reports two flags. Input-ready means the store is not full. Output-ready means the store is not empty. A sticky data-late flag is raised when the store is misused. Misuse means a read-type command while the store is full, a write command while it is empty, a pop from an empty store, or a push into a full store. The store is flushed by any of these events: a valid command start, a write of one to the transfer-error bit, the bridge clear, or the controller clear. The error clear resets the data-late flag and blanks both ready flags for one cycle, but it leaves the stored words in place.

Access is by full word only; the block has no byte lanes. Every input is sampled on the rising clock edge. Each output reflects the edge at which its input was sampled. Reset is synchronous and active high, and it acts as a bridge clear.

Top module: `diag_dbuf`

## Requirements
- R1: After 66 accepted pushes into an empty store, in_rdy is 0 from the edge of the 66th push. Outside a clear, in_rdy is 1 whenever fewer than 66 words are held.
- R2: Outside a clear, out_rdy is 1 whenever at least one word is held, and 0 when the store is empty.
- R3: Words are returned oldest first. db_rdata takes the popped word at the edge that samples db_rd and holds it until the next pop. A push and a pop in the same cycle both take effect.
- R4: cmd_read or cmd_wrchk sampled while 66 words are held sets data_late.
- R5: cmd_write sampled while the store is empty sets data_late. A pop from an empty store also sets data_late and makes db_rdata 0. cmd_write with a non-empty store leaves data_late unchanged.
- R6: A push while the store is full is dropped and sets data_late. The held words and their order are unchanged.
- R7: tre_set, go_valid, bridge_clr or ctrl_clr empties the store at that edge. A flush takes priority over a push made in the same cycle.
- R8: data_late stays set until bridge_clr, ctrl_clr, err_clr or rst is sampled. A clear wins over a set in the same cycle.
- R9: For one cycle after bridge_clr, ctrl_clr or err_clr is sampled, both in_rdy and out_rdy read 0. err_clr does not remove stored words.
- R10: While rst is sampled, in_rdy, out_rdy, data_late and db_rdata are 0. One cycle after rst falls, in_rdy is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| db_wr | input | 1 | Bus write strobe to the data register (push) |
| db_wdata | input | 16 | Word to push |
| db_rd | input | 1 | Bus read strobe from the data register (pop) |
| db_rdata | output | 16 | Last popped word; 0 after a pop from an empty store |
| cmd_read | input | 1 | Read command issued |
| cmd_wrchk | input | 1 | Write-check command issued |
| cmd_write | input | 1 | Write command issued |
| go_valid | input | 1 | Command start with a valid function (flushes) |
| tre_set | input | 1 | One written to the transfer-error bit (flushes) |
| bridge_clr | input | 1 | Bridge clear |
| ctrl_clr | input | 1 | Controller clear |
| err_clr | input | 1 | Error clear |
| in_rdy | output | 1 | Store not full |
| out_rdy | output | 1 | Store not empty |
| data_late | output | 1 | Sticky misuse flag |

## Verification
A wrong fill count first shows on the ready flags. An off-by-one in the depth moves the edge at which in_rdy falls away from the 66th push. A count that fails to return to zero keeps out_rdy high after the last pop. A pointer that wraps incorrectly returns the wrong word on the first pop that crosses the end of the storage, or a word from before a flush. Each of these shows at the ports in the cycle right after the offending edge. A reference queue compared on every clock therefore catches the fault at that cycle.

// File: rtl/dfb_pkg.sv
package dfb_pkg;
  typedef struct packed {
    logic bridge;
    logic ctrl;
    logic err;
  } clr_src_t;

  localparam int unsigned DFB_WIDTH = 16;
  localparam int unsigned DFB_DEPTH = 66;
endpackage

// File: rtl/dfb_store.sv
module dfb_store #(
  parameter int unsigned WIDTH = 16,
  parameter int unsigned DEPTH = 66
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             push,
  input  logic [WIDTH-1:0] wdata,
  input  logic             pop,
  output logic [WIDTH-1:0] rdata,
  output logic             full,
  output logic             empty
);
  localparam int unsigned PTR_W = $clog2(DEPTH);
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wptr, rptr;
  logic [CNT_W-1:0] cnt;
  logic [WIDTH-1:0] mem_q;
  logic             zero_q;
  logic             push_ok, pop_ok;

  assign full    = (cnt == CNT_W'(DEPTH));
  assign empty   = (cnt == '0);
  assign push_ok = push & ~full;
  assign pop_ok  = pop & ~empty;

  // storage array: plain write port, no reset, so block RAM can be inferred
  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr] <= wdata;
  end

  // registered read port, enabled by the pop strobe
  always_ff @(posedge clk) begin
    if (pop) mem_q <= mem[rptr];
  end

  always_ff @(posedge clk) begin
    if (rst)      zero_q <= 1'b1;
    else if (pop) zero_q <= empty;
  end

  assign rdata = zero_q ? '0 : mem_q;

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else begin
      if (push_ok) wptr <= (wptr == PTR_W'(DEPTH - 1)) ? '0 : wptr + 1'b1;
      if (pop_ok)  rptr <= (rptr == PTR_W'(DEPTH - 1)) ? '0 : rptr + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  p_count_bound_r1: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_W'(DEPTH));
  p_flush_empties_r7: assert property (@(posedge clk) disable iff (rst)
    flush |=> empty);
  p_full_drops_push_r6: assert property (@(posedge clk) disable iff (rst)
    (push && !pop && full && !flush) |=> full);
  p_empty_pop_zero_r5: assert property (@(posedge clk) disable iff (rst)
    (pop && empty) |=> (rdata == '0));
endmodule

// File: rtl/dfb_flags.sv
module dfb_flags
  import dfb_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  clr_src_t clr,
  input  logic     full,
  input  logic     empty,
  input  logic     push,
  input  logic     pop,
  input  logic     cmd_read,
  input  logic     cmd_wrchk,
  input  logic     cmd_write,
  output logic     in_rdy,
  output logic     out_rdy,
  output logic     data_late
);
  logic any_clr, clr_q, late_q, late_set;

  assign any_clr  = rst | clr.bridge | clr.ctrl | clr.err;
  assign late_set = ((cmd_read | cmd_wrchk) & full)
                  | (cmd_write & empty)
                  | (pop & empty)
                  | (push & full);

  always_ff @(posedge clk) begin
    clr_q <= any_clr;
    if (any_clr)       late_q <= 1'b0;
    else if (late_set) late_q <= 1'b1;
  end

  assign in_rdy    = ~clr_q & ~full;
  assign out_rdy   = ~clr_q & ~empty;
  assign data_late = late_q;

  p_late_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    (data_late && !any_clr) |=> data_late);
  p_clr_blanks_rdy_r9: assert property (@(posedge clk) disable iff (rst)
    any_clr |=> (!in_rdy && !out_rdy));
  p_late_cmd_full_r4: assert property (@(posedge clk) disable iff (rst)
    (!any_clr && (cmd_read || cmd_wrchk) && full) |=> data_late);
endmodule

// File: rtl/diag_dbuf.sv
module diag_dbuf
  import dfb_pkg::*;
#(
  parameter int unsigned WIDTH = DFB_WIDTH,
  parameter int unsigned DEPTH = DFB_DEPTH
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             db_wr,
  input  logic [WIDTH-1:0] db_wdata,
  input  logic             db_rd,
  output logic [WIDTH-1:0] db_rdata,
  input  logic             cmd_read,
  input  logic             cmd_wrchk,
  input  logic             cmd_write,
  input  logic             go_valid,
  input  logic             tre_set,
  input  logic             bridge_clr,
  input  logic             ctrl_clr,
  input  logic             err_clr,
  output logic             in_rdy,
  output logic             out_rdy,
  output logic             data_late
);
  clr_src_t clr;
  logic     flush, full, empty;

  assign clr   = '{bridge: bridge_clr, ctrl: ctrl_clr, err: err_clr};
  assign flush = tre_set | go_valid | bridge_clr | ctrl_clr;

  dfb_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_store (
    .clk   (clk),
    .rst   (rst),
    .flush (flush),
    .push  (db_wr),
    .wdata (db_wdata),
    .pop   (db_rd),
    .rdata (db_rdata),
    .full  (full),
    .empty (empty)
  );

  dfb_flags u_flags (
    .clk       (clk),
    .rst       (rst),
    .clr       (clr),
    .full      (full),
    .empty     (empty),
    .push      (db_wr),
    .pop       (db_rd),
    .cmd_read  (cmd_read),
    .cmd_wrchk (cmd_wrchk),
    .cmd_write (cmd_write),
    .in_rdy    (in_rdy),
    .out_rdy   (out_rdy),
    .data_late (data_late)
  );

  p_reset_quiet_r10: assert property (@(posedge clk)
    rst |=> (!in_rdy && !out_rdy && !data_late && db_rdata == '0));
endmodule

// File: tb/diag_dbuf_bench.sv
module diag_dbuf_bench;
  localparam int DEPTH = 66;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst = 1'b1;
  logic        db_wr = 0, db_rd = 0, cmd_read = 0, cmd_wrchk = 0, cmd_write = 0;
  logic        go_valid = 0, tre_set = 0, bridge_clr = 0, ctrl_clr = 0, err_clr = 0;
  logic [15:0] db_wdata = '0;
  logic [15:0] db_rdata;
  logic        in_rdy, out_rdy, data_late;

  diag_dbuf u_diag_dbuf (
    .clk(clk), .rst(rst), .db_wr(db_wr), .db_wdata(db_wdata), .db_rd(db_rd),
    .db_rdata(db_rdata), .cmd_read(cmd_read), .cmd_wrchk(cmd_wrchk),
    .cmd_write(cmd_write), .go_valid(go_valid), .tre_set(tre_set),
    .bridge_clr(bridge_clr), .ctrl_clr(ctrl_clr), .err_clr(err_clr),
    .in_rdy(in_rdy), .out_rdy(out_rdy), .data_late(data_late)
  );

  int          checks = 0, fails = 0;
  bit          done = 0;
  logic [15:0] q[$];
  logic        m_late = 0, m_clr = 1;
  logic [15:0] m_rd = '0;

  task automatic step(input string tag);
    bit fl, em, anyc, flush;
    logic [15:0] xr;
    @(posedge clk);
    fl = (q.size() == DEPTH);
    em = (q.size() == 0);
    anyc = rst | bridge_clr | ctrl_clr | err_clr;
    flush = rst | bridge_clr | ctrl_clr | tre_set | go_valid;
    if (anyc) m_late = 0;
    else if (((cmd_read | cmd_wrchk) & fl) | (cmd_write & em) | (db_rd & em) | (db_wr & fl))
      m_late = 1;
    if (rst) m_rd = '0;
    else if (db_rd) m_rd = em ? 16'h0 : q[0];
    if (flush) q.delete();
    else begin
      if (db_rd && !em) xr = q.pop_front();
      if (db_wr && !fl) q.push_back(db_wdata);
    end
    m_clr = anyc;
    #1;
    checks++;
    if (in_rdy !== (!m_clr && q.size() != DEPTH) || out_rdy !== (!m_clr && q.size() != 0)
        || data_late !== m_late || db_rdata !== m_rd) begin
      fails++;
      $display("FAIL %s: actual in=%b out=%b late=%b rd=%h expected in=%b out=%b late=%b rd=%h",
               tag, in_rdy, out_rdy, data_late, db_rdata,
               (!m_clr && q.size() != DEPTH), (!m_clr && q.size() != 0), m_late, m_rd);
    end
    @(negedge clk);
    {rst, db_wr, db_rd, cmd_read, cmd_wrchk, cmd_write} = '0;
    {go_valid, tre_set, bridge_clr, ctrl_clr, err_clr} = '0;
  endtask

  task automatic push(input logic [15:0] d, input string tag);
    db_wr = 1; db_wdata = d; step(tag);
  endtask

  task automatic pop(input string tag);
    db_rd = 1; step(tag);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired (all requirements)");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    rst = 1; step("R10");
    rst = 1; step("R10");
    step("R10");                              // in_rdy rises after reset
    for (int i = 0; i < 5; i++) push(16'hA000 + 16'(i), "R2");
    for (int i = 0; i < 5; i++) pop("R3");
    pop("R5");                                // empty pop -> zero, late
    step("R8"); step("R8");                   // sticky
    cmd_write = 1; step("R8");
    err_clr = 1; step("R8");
    step("R9");
    for (int i = 0; i < 3; i++) push(16'h5100 + 16'(i), "R2");
    cmd_write = 1; step("R5");                // non-empty write cmd: no late
    err_clr = 1; step("R9");                  // blanks flags, keeps words
    step("R9");
    pop("R9"); pop("R3");
    db_wr = 1; db_rd = 1; db_wdata = 16'h7777; step("R3");
    pop("R3"); pop("R3");
    cmd_write = 1; step("R5");                // write cmd on empty
    ctrl_clr = 1; step("R8");
    for (int i = 0; i < DEPTH; i++) push(16'hC000 + 16'(i), "R1");
    push(16'hDEAD, "R6");
    step("R6");
    bridge_clr = 1; db_wr = 1; db_wdata = 16'hBEEF; step("R7");
    step("R1");
    for (int i = 0; i < DEPTH; i++) push(16'h3000 + 16'(i), "R1");
    cmd_read = 1; step("R4");
    err_clr = 1; step("R9");
    step("R9");
    cmd_wrchk = 1; step("R4");
    db_wr = 1; db_rd = 1; db_wdata = 16'h1111; step("R6");
    pop("R1");
    for (int i = 0; i < 8; i++) pop("R3");
    tre_set = 1; step("R7");
    push(16'h4242, "R2");
    go_valid = 1; step("R7");
    pop("R7");
    push(16'h9999, "R2");
    ctrl_clr = 1; step("R7");
    step("R2");
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule